// File: doc/BRIEF.md
# Sampled Channel Edge Trigger with Change Detection

This block sits between the sample-rate divider and the capture buffer of a logic capture path. It watches a bus of logic channels but takes a new sample only in cycles where the divided sample strobe is high. A single register holds the last sampled word. Two checks use that register. The first compares the incoming word with the held word and raises a one-cycle change event when any channel differs. The buffer uses this event to open a new record. The second check looks at one channel, picked by an index input, for a transition in the configured direction.

When the selected channel makes the configured transition while the arm input is high, a sticky triggered flag is set. The capture buffer uses this flag to stop overwriting its pre-trigger history and to start filling the post-trigger part. The flag stays set until an explicit clear pulse, or until arm goes from low to high again. The held word is also an output, so the buffer can store it next to a timestamp.

Top module: `edge_trigger_top`

## Requirements
- R1: After reset, `change_evt` is 0, `trig_flag` is 0 and `held_word` is all zeros.
- R2: `held_word` takes the value of `chan_in` only at a clock edge where `smp_stb` is 1. The new value is visible after that edge. At all other times `held_word` holds its value.
- R3: `change_evt` is 1 only in a cycle where `smp_stb` is 1 and `chan_in` differs from `held_word` in at least one bit. It is high for that single cycle only.
- R4: The first strobed sample after reset only loads `held_word`. It produces no change event and cannot set `trig_flag`.
- R5: When `edge_rise` is 1 (rising), a strobed sample in which channel `chan_sel` goes from 0 in `held_word` to 1 in `chan_in`, with `arm` at 1, sets `trig_flag` at that clock edge. A transition from 1 to 0 does not set it.
- R6: When `edge_rise` is 0 (falling), a strobed transition of channel `chan_sel` from 1 to 0 with `arm` at 1 sets `trig_flag`. A transition from 0 to 1 does not set it.
- R7: Transitions on any channel other than `chan_sel` never set `trig_flag`.
- R8: While `arm` is 0, no transition sets `trig_flag`.
- R9: Once set, `trig_flag` stays 1 whatever the channels do, until `clr` is 1 at a clock edge. It reads 0 after that edge.
- R10: A clock edge at which `arm` has gone from 0 to 1 since the previous edge clears `trig_flag`.
- R11: If `clr` is 1 in the same cycle as a matching edge, the clear wins and `trig_flag` reads 0 after that edge.
- R12: Changes on `chan_in` without `smp_stb` have no effect. They produce no event, do not update `held_word` and do not set `trig_flag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| smp_stb | input | 1 | Sample strobe from the rate divider |
| chan_in | input | CH_W | Channel bus to be sampled |
| chan_sel | input | IDX_W | Index of the trigger channel |
| edge_rise | input | 1 | Edge direction: 1 = rising, 0 = falling |
| arm | input | 1 | Enables trigger detection; its rising edge clears the flag |
| clr | input | 1 | Clears the triggered flag |
| change_evt | output | 1 | One-cycle pulse when a strobed sample differs from the held word |
| held_word | output | CH_W | Last strobed sample |
| trig_flag | output | 1 | Sticky triggered status |

## Verification
A corrupt held word shows up at once, in two ways. `held_word` reads wrong in the cycle after the strobe that loaded it. The next strobe then produces a spurious or missing `change_evt`, and can set `trig_flag` falsely. If the primed state is lost or set too early, the difference appears on the first strobe after reset as an event or trigger that should not be there. A fault in the sticky flag logic shows as `trig_flag` dropping without `clr` or an arm rise, or surviving one of them. The bench catches this at the clock edge right after the stimulus.

// File: rtl/trig_pkg.sv
// Package: shared types for the edge trigger block.
// Assumes: nothing beyond the standard language.
package trig_pkg;
    // Direction of the transition the trigger watches for.
    typedef enum logic {
        EDGE_FALL = 1'b0,
        EDGE_RISE = 1'b1
    } edge_dir_e;
endpackage

// File: rtl/sample_hold.sv
// Module: sample_hold
// Keeps the last strobed channel word and a primed flag.
// The primed flag marks that the word holds a real sample.
// Assumes: smp_stb is a single-cycle qualifier synchronous to clk.
module sample_hold #(
    parameter int CH_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            stb,
    input  logic [CH_W-1:0] din,
    output logic [CH_W-1:0] held,
    output logic            primed
);
    // Capture the sample and mark the register valid on each strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held   <= '0;
            primed <= 1'b0;
        end else if (stb) begin
            held   <= din;
            primed <= 1'b1;
        end
    end
endmodule

// File: rtl/change_detect.sv
// Module: change_detect
// Flags, in the strobe cycle itself, any difference between the
// incoming word and the held word.
// Assumes: held is valid only when primed is 1.
module change_detect #(
    parameter int CH_W = 8
) (
    input  logic            stb,
    input  logic            primed,
    input  logic [CH_W-1:0] din,
    input  logic [CH_W-1:0] held,
    output logic            evt
);
    logic any_diff;

    // Reduce the bitwise difference to one change bit.
    always_comb begin
        any_diff = |(din ^ held);
        evt      = stb && primed && any_diff;
    end
endmodule

// File: rtl/edge_trig.sv
// Module: edge_trig
// Detects the configured transition on one selected channel and keeps
// a sticky triggered flag.
// Assumes: CH_W is a power of two, so every index value is a real channel.
module edge_trig #(
    parameter int CH_W  = 8,
    parameter int IDX_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stb,
    input  logic              primed,
    input  logic [CH_W-1:0]   din,
    input  logic [CH_W-1:0]   held,
    input  logic [IDX_W-1:0]  sel,
    input  trig_pkg::edge_dir_e dir,
    input  logic              arm,
    input  logic              clr,
    output logic              trig
);
    import trig_pkg::*;

    logic new_bit, old_bit, edge_hit, arm_d, arm_rise, match;

    // Pick the watched channel and decide whether its transition matches.
    always_comb begin
        new_bit  = din[sel];
        old_bit  = held[sel];
        edge_hit = (dir == EDGE_RISE) ? (!old_bit && new_bit)
                                      : (old_bit && !new_bit);
        arm_rise = arm && !arm_d;
        match    = stb && primed && arm && edge_hit;
    end

    // Remember arm so that its rising edge can be seen.
    always_ff @(posedge clk) begin
        if (!rst_n) arm_d <= 1'b0;
        else        arm_d <= arm;
    end

    // Sticky flag: a clear or re-arm wins over a new match.
    always_ff @(posedge clk) begin
        if (!rst_n)               trig <= 1'b0;
        else if (clr || arm_rise) trig <= 1'b0;
        else if (match)           trig <= 1'b1;
    end
endmodule

// File: rtl/edge_trigger_top.sv
// Module: edge_trigger_top
// Strobed sampling of a channel bus, with change events and a sticky
// single-channel edge trigger for a capture buffer.
// Assumes: smp_stb comes from a rate divider in the same clock domain.
module edge_trigger_top #(
    parameter int CH_W  = 8,
    parameter int IDX_W = (CH_W > 1) ? $clog2(CH_W) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             smp_stb,
    input  logic [CH_W-1:0]  chan_in,
    input  logic [IDX_W-1:0] chan_sel,
    input  logic             edge_rise,
    input  logic             arm,
    input  logic             clr,
    output logic             change_evt,
    output logic [CH_W-1:0]  held_word,
    output logic             trig_flag
);
    import trig_pkg::*;

    logic      primed;
    edge_dir_e dir;

    // Map the raw polarity pin onto the direction type.
    always_comb dir = edge_dir_e'(edge_rise);

    sample_hold #(.CH_W(CH_W)) hold_i (
        .clk(clk), .rst_n(rst_n), .stb(smp_stb), .din(chan_in),
        .held(held_word), .primed(primed)
    );

    change_detect #(.CH_W(CH_W)) chg_i (
        .stb(smp_stb), .primed(primed), .din(chan_in), .held(held_word),
        .evt(change_evt)
    );

    edge_trig #(.CH_W(CH_W), .IDX_W(IDX_W)) trg_i (
        .clk(clk), .rst_n(rst_n), .stb(smp_stb), .primed(primed),
        .din(chan_in), .held(held_word), .sel(chan_sel), .dir(dir),
        .arm(arm), .clr(clr), .trig(trig_flag)
    );
endmodule

// File: rtl/edge_trigger_chk.sv
// Module: edge_trigger_chk
// Port-level properties for edge_trigger_top, attached by bind.
// Assumes: rst_n is held low for at least one clock at start.
module edge_trigger_chk #(
    parameter int CH_W  = 8,
    parameter int IDX_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             smp_stb,
    input logic [CH_W-1:0]  chan_in,
    input logic             arm,
    input logic             clr,
    input logic             change_evt,
    input logic [CH_W-1:0]  held_word,
    input logic             trig_flag
);
    // An event only appears in a strobe cycle, and only on a real difference.
    assert_evt_needs_stb_R3: assert property (@(posedge clk) disable iff (!rst_n)
        change_evt |-> (smp_stb && (chan_in != held_word)));

    // Without a strobe, the held word does not move.
    assert_hold_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_stb |=> $stable(held_word));

    // The flag is only set by an armed, strobed sample.
    assert_set_needs_arm_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!trig_flag && !(arm && smp_stb)) |=> !trig_flag);

    // A clear always leaves the flag low.
    assert_clear_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !trig_flag);

    // Without a clear or re-arm, a set flag stays set.
    assert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_flag && !clr && !$rose(arm)) |=> trig_flag);
endmodule

bind edge_trigger_top edge_trigger_chk #(.CH_W(CH_W), .IDX_W(IDX_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb), .chan_in(chan_in),
    .arm(arm), .clr(clr), .change_evt(change_evt), .held_word(held_word),
    .trig_flag(trig_flag)
);

// File: tb/edge_trigger_top_tb_top.sv
module edge_trigger_top_tb_top;
    localparam int CH_W  = 8;
    localparam int IDX_W = 3;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             smp_stb = 1'b0;
    logic [CH_W-1:0]  chan_in = '0;
    logic [IDX_W-1:0] chan_sel = '0;
    logic             edge_rise = 1'b1;
    logic             arm = 1'b0;
    logic             clr = 1'b0;
    logic             change_evt;
    logic [CH_W-1:0]  held_word;
    logic             trig_flag;

    int n_chk = 0;
    int n_fail = 0;
    logic            m_primed = 1'b0;
    logic [CH_W-1:0] m_held = '0;
    bit done = 0;

    always #2 clk = ~clk;

    edge_trigger_top #(.CH_W(CH_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb), .chan_in(chan_in),
        .chan_sel(chan_sel), .edge_rise(edge_rise), .arm(arm), .clr(clr),
        .change_evt(change_evt), .held_word(held_word), .trig_flag(trig_flag)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One strobed sample; checks the event in the strobe cycle and the word after.
    task automatic strobe(input logic [CH_W-1:0] w, input logic with_clr, input string req);
        logic exp_ev;
        @(negedge clk);
        chan_in = w; smp_stb = 1'b1; clr = with_clr;
        #1;
        exp_ev = m_primed && (w != m_held);
        check({req, " R3 event"}, int'(change_evt), int'(exp_ev));
        @(negedge clk);
        smp_stb = 1'b0; clr = 1'b0;
        m_held = w; m_primed = 1'b1;
        #1;
        check({req, " R2 word"}, int'(held_word), int'(w));
        check({req, " R3 one-cycle"}, int'(change_evt), 0);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R1 evt", int'(change_evt), 0);
        check("R1 trig", int'(trig_flag), 0);
        check("R1 word", int'(held_word), 0);
    endtask

    task automatic t_first();
        @(negedge clk); arm = 1'b1; edge_rise = 1'b1; chan_sel = 3'd0;
        strobe(8'hA5, 1'b0, "R4 first");
        check("R4 no trig on first", int'(trig_flag), 0);
    endtask

    task automatic t_no_strobe();
        @(negedge clk); chan_sel = 3'd1; chan_in = 8'hFF;
        for (int i = 0; i < 3; i++) begin
            #1;
            check("R12 evt", int'(change_evt), 0);
            @(negedge clk);
        end
        check("R12 word", int'(held_word), 'hA5);
        check("R12 trig", int'(trig_flag), 0);
    endtask

    task automatic t_disarmed();
        @(negedge clk); arm = 1'b0;
        strobe(8'hFF, 1'b0, "R8 change");
        check("R8 trig while disarmed", int'(trig_flag), 0);
        strobe(8'hFF, 1'b0, "R3 same");
    endtask

    task automatic t_rising();
        @(negedge clk); arm = 1'b1; chan_sel = 3'd2; edge_rise = 1'b1;
        strobe(8'hFB, 1'b0, "R5 fall");
        check("R5 falling ignored", int'(trig_flag), 0);
        strobe(8'hF3, 1'b0, "R7 other");
        check("R7 other channel", int'(trig_flag), 0);
        strobe(8'hF7, 1'b0, "R5 rise");
        check("R5 rising sets", int'(trig_flag), 1);
    endtask

    task automatic t_sticky();
        strobe(8'hF3, 1'b0, "R9 toggle");
        strobe(8'hF7, 1'b0, "R9 toggle");
        check("R9 stays set", int'(trig_flag), 1);
        @(negedge clk); clr = 1'b1;
        @(negedge clk); clr = 1'b0;
        #1;
        check("R9 cleared", int'(trig_flag), 0);
    endtask

    task automatic t_falling();
        @(negedge clk); edge_rise = 1'b0; chan_sel = 3'd5;
        strobe(8'hD7, 1'b0, "R6 fall");
        check("R6 falling sets", int'(trig_flag), 1);
    endtask

    task automatic t_rearm();
        @(negedge clk); arm = 1'b0;
        @(negedge clk); arm = 1'b1;
        @(negedge clk);
        #1;
        check("R10 rearm clears", int'(trig_flag), 0);
    endtask

    task automatic t_clear_prio();
        strobe(8'hF7, 1'b0, "R6 rise");
        check("R6 rising ignored", int'(trig_flag), 0);
        strobe(8'hD7, 1'b1, "R11 edge+clr");
        check("R11 clear wins", int'(trig_flag), 0);
        strobe(8'hF7, 1'b0, "R11 again");
        strobe(8'hD7, 1'b0, "R11 again");
        check("R11 still triggers later", int'(trig_flag), 1);
    endtask

    initial begin
        t_reset();
        t_first();
        t_no_strobe();
        t_disarmed();
        t_rising();
        t_sticky();
        t_falling();
        t_rearm();
        t_clear_prio();
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_chk++; n_fail++;
                $display("FAIL watchdog actual=timeout expected=finish");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule